// File: doc/BRIEF.md
# Dual UART Character FIFO with Fill Counters

This block sits between a UART serialiser core and a 16-bit register bus. It holds two character queues of 128 entries each: a transmit queue that software fills through the data register and the core drains, and a receive queue that the core fills and software drains. A control register enables each queue, empties either one with a self-clearing command bit, and holds the interrupt enables and a transmit data-request flag. A fill register reports how full both queues are.

The core side uses two ready/valid character handshakes. The block raises a transmit interrupt when the transmit queue has run dry and software asked to be told. It raises a receive interrupt when the receive fill reaches a programmed threshold, or when unread characters have been sitting with no new arrival for a fixed number of character times. Character times are marked by a one-cycle tick from the core's baud logic.

Top module: `dual_uart_fifo`

## Requirements
- R1: After reset both fills read 0, the control register reads 0, `tx_valid`, `rx_ready`, `tx_irq` and `rx_irq` are low and the receive threshold is 0.
- R2: A bus write to offset 4 with the transmit queue enabled and not full appends `bus_wdata[7:0]`. `tx_valid` is high whenever the transmit queue is enabled and not empty, and `tx_data` shows the oldest entry. One entry is removed on each cycle where `tx_valid` and `tx_ready` are both high, in first-in first-out order.
- R3: Each queue holds at most 128 characters. A data write to a full transmit queue is dropped, and `rx_ready` is low while the receive queue is full.
- R4: A read of offset 14 returns the transmit fill in bits 7:0 and the receive fill in bits 15:8.
- R5: Control register at offset 12: bit 0 enables the transmit queue and bit 1 enables the receive queue. With transmit disabled, data writes are dropped and `tx_valid` is low. With receive disabled, `rx_ready` is low.
- R6: Writing 1 to control bit 2 empties the transmit queue, and writing 1 to bit 3 empties the receive queue. The fill reads 0 from the next cycle, and both bits always read back as 0.
- R7: Control bit 10 is a data-request flag. Hardware sets it one cycle after any cycle in which bit 9 is 1 and the transmit queue is empty. A control write with bit 10 at 0 clears it unless hardware sets it in the same cycle. Writing 1 to bit 10 never sets it.
- R8: `tx_irq` is high exactly when control bits 9 and 10 are both 1.
- R9: A bus read of offset 4 returns the oldest receive entry in bits 7:0 and removes it. A read of offset 4 with the receive queue empty returns 0 and changes nothing.
- R10: A write to offset 14 loads the receive threshold from `bus_wdata[15:8]`. While the threshold is non-zero and the receive fill is at least the threshold, `rx_irq` is high.
- R11: With control bit 11 set and the receive queue non-empty, `rx_irq` rises after 4 (`IDLE_TICKS`) `char_tick` pulses with no character accepted from the core. Any accepted character, or an empty receive queue, restarts the count.
- R12: Control bits 4 to 8 and 12 to 15 read as 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at offset 4) |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | Transmit character available to the core |
| tx_data | output | 8 | Oldest transmit character |
| tx_ready | input | 1 | Core takes the transmit character |
| rx_valid | input | 1 | Core offers a received character |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Receive queue can accept a character |
| char_tick | input | 1 | One pulse per character time |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Read data is combinational, so it is checked in the same cycle the address is presented, one time unit after the inputs change. Every other effect of a write or handshake sampled at an edge shows on the outputs and the fill register right after that edge. The one exception is the data-request flag, which lags its condition by one register stage, so it is due two edges after the enable is written. The bench advances a queue-based model at each rising edge with the inputs the design saw, then compares every output at the following falling edge. The idle interrupt is therefore expected right after the edge that samples the fourth tick.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 4;

  localparam logic [ADR_W-1:0] OFS_DATA = 4'd4;
  localparam logic [ADR_W-1:0] OFS_CTRL = 4'd12;
  localparam logic [ADR_W-1:0] OFS_FILL = 4'd14;

  // control word bit positions
  localparam int B_TX_ON   = 0;
  localparam int B_RX_ON   = 1;
  localparam int B_TX_FLSH = 2;
  localparam int B_RX_FLSH = 3;
  localparam int B_TX_IEN  = 9;
  localparam int B_TX_REQ  = 10;
  localparam int B_RX_IIEN = 11;

  typedef struct packed {
    logic tx_on;
    logic rx_on;
    logic tx_ien;
    logic rx_iien;
  } ctl_t;

  function automatic logic [REG_W-1:0] pack_fill(input logic [7:0] txf, input logic [7:0] rxf);
    return {rxf, txf};
  endfunction

  function automatic logic level_hit(input logic [7:0] fill, input logic [7:0] thr);
    return (thr != 8'd0) && (fill >= thr);
  endfunction
endpackage

// File: rtl/dfifo_buf.sv
module dfifo_buf #(
  parameter int DEPTH = 128,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] rp, wp;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = store[rp];

  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rp   <= '0;
      wp   <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wp <= adv(wp);
      if (pop_ok)  rp <= adv(rp);
      fill <= fill + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0));
  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (fill == $past(fill)) || (fill == $past(fill) + CW'(1)) || (fill == $past(fill) - CW'(1)));
endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl
  import dfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             thr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_empty,
  output ctl_t             ctl,
  output logic             tx_req,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic [7:0]       rx_thr,
  output logic             tx_irq,
  output logic [REG_W-1:0] ctl_word
);
  logic req_set, req_clr;

  assign req_set  = ctl.tx_ien && tx_empty;
  assign req_clr  = ctl_wr && !wdata[B_TX_REQ];
  assign tx_flush = ctl_wr && wdata[B_TX_FLSH];
  assign rx_flush = ctl_wr && wdata[B_RX_FLSH];
  assign tx_irq   = ctl.tx_ien && tx_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      tx_req <= 1'b0;
      rx_thr <= '0;
    end else begin
      if (ctl_wr) begin
        ctl.tx_on   <= wdata[B_TX_ON];
        ctl.rx_on   <= wdata[B_RX_ON];
        ctl.tx_ien  <= wdata[B_TX_IEN];
        ctl.rx_iien <= wdata[B_RX_IIEN];
      end
      if (thr_wr) rx_thr <= wdata[15:8];
      if (req_set)      tx_req <= 1'b1;
      else if (req_clr) tx_req <= 1'b0;
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[B_TX_ON]   = ctl.tx_on;
    ctl_word[B_RX_ON]   = ctl.rx_on;
    ctl_word[B_TX_IEN]  = ctl.tx_ien;
    ctl_word[B_TX_REQ]  = tx_req;
    ctl_word[B_RX_IIEN] = ctl.rx_iien;
  end

  p_req_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.tx_ien && tx_empty) |=> tx_req);
  p_req_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && !req_set) |=> !tx_req);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (ctl.tx_ien && tx_req));
endmodule

// File: rtl/dfifo_rx_idle.sv
module dfifo_rx_idle #(
  parameter int IDLE_TICKS = 4,
  localparam int TW = $clog2(IDLE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_push,
  input  logic rx_empty,
  input  logic flush,
  input  logic char_tick,
  input  logic iien,
  output logic idle_hit
);
  logic [TW-1:0] ticks;
  logic          restart, saturated;

  assign restart   = rx_push || rx_empty || flush;
  assign saturated = (ticks == TW'(IDLE_TICKS));
  assign idle_hit  = iien && !rx_empty && saturated;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)           ticks <= '0;
    else if (char_tick && !saturated) ticks <= ticks + TW'(1);
  end

  p_ticks_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ticks <= TW'(IDLE_TICKS));
  p_push_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (ticks == '0));
endmodule

// File: rtl/dual_uart_fifo.sv
module dual_uart_fifo
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DATA_W = 8,
  parameter int IDLE_TICKS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              char_tick,
  output logic              tx_irq,
  output logic              rx_irq
);
  ctl_t              ctl;
  logic              tx_req, tx_flush, rx_flush;
  logic [7:0]        rx_thr;
  logic [REG_W-1:0]  ctl_word;
  logic [CW-1:0]     tx_fill, rx_fill;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              tx_push, tx_pop, rx_push, rx_pop, idle_hit;
  logic              wr_ctl, wr_thr, wr_dat, rd_dat;

  assign wr_ctl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_thr  = bus_wr && (bus_addr == OFS_FILL);
  assign wr_dat  = bus_wr && (bus_addr == OFS_DATA);
  assign rd_dat  = bus_rd && (bus_addr == OFS_DATA);

  assign tx_push  = wr_dat && ctl.tx_on;
  assign tx_valid = ctl.tx_on && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_ready = ctl.rx_on && !rx_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd_dat;

  dfifo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .thr_wr(wr_thr), .wdata(bus_wdata),
    .tx_empty(tx_empty), .ctl(ctl), .tx_req(tx_req), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .rx_thr(rx_thr), .tx_irq(tx_irq), .ctl_word(ctl_word)
  );

  dfifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(bus_wdata[DATA_W-1:0]), .pop(tx_pop), .dout(tx_data),
    .fill(tx_fill), .full(tx_full), .empty(tx_empty)
  );

  dfifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
    .din(rx_data), .pop(rx_pop), .dout(rx_head),
    .fill(rx_fill), .full(rx_full), .empty(rx_empty)
  );

  dfifo_rx_idle #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_empty(rx_empty),
    .flush(rx_flush), .char_tick(char_tick), .iien(ctl.rx_iien), .idle_hit(idle_hit)
  );

  assign rx_irq = level_hit(8'(rx_fill), rx_thr) || idle_hit;

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = rx_empty ? '0 : REG_W'(rx_head);
      OFS_CTRL: bus_rdata = ctl_word;
      OFS_FILL: bus_rdata = pack_fill(8'(tx_fill), 8'(rx_fill));
      default:  bus_rdata = '0;
    endcase
  end

  p_txfull_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop && !tx_flush) |=> tx_full);
  p_tx_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tx_on |-> !tx_valid);
  p_rx_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !rx_push) |=> rx_empty);
  p_thr_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_thr != 8'd0) && (8'(rx_fill) >= rx_thr)) |-> rx_irq);
endmodule

// File: tb/test_dual_uart_fifo.sv
module test_dual_uart_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, tx_ready, rx_valid, char_tick;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [7:0]  rx_data;
  logic [15:0] bus_rdata;
  logic        tx_valid, rx_ready, tx_irq, rx_irq;
  logic [7:0]  tx_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dual_uart_fifo i_dual_uart_fifo (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .char_tick(char_tick), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // behavioural reference state
  byte unsigned mtx[$];
  byte unsigned mrx[$];
  bit  m_txon, m_rxon, m_tien, m_req, m_riien;
  int  m_thr, m_idle;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    case (bus_addr)
      4'd4:  return (mrx.size() > 0) ? int'(mrx[0]) : 0;
      4'd12: return (int'(m_riien) << 11) | (int'(m_req) << 10) | (int'(m_tien) << 9)
                    | (int'(m_rxon) << 1) | int'(m_txon);
      4'd14: return (mrx.size() << 8) | mtx.size();
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (bus_addr)
      4'd4:  return "R9 data read";
      4'd12: return "R5 control read";
      4'd14: return "R4 fill read";
      default: return "R12 unmapped read";
    endcase
  endfunction

  task automatic model_step();
    int  ntx = mtx.size();
    int  nrx = mrx.size();
    bool_blk: begin
      bit wctl = bus_wr && bus_addr == 4'd12;
      bit txv  = m_txon && ntx > 0;
      bit rxr  = m_rxon && nrx < 128;
      bit rpush = rx_valid && rxr;
      bit setq = m_tien && ntx == 0;
      // idle counter
      if (rpush || nrx == 0 || (wctl && bus_wdata[3])) m_idle = 0;
      else if (char_tick && m_idle < 4) m_idle++;
      // transmit queue
      if (wctl && bus_wdata[2]) mtx.delete();
      else begin
        if (txv && tx_ready) void'(mtx.pop_front());
        if (bus_wr && bus_addr == 4'd4 && m_txon && ntx < 128) mtx.push_back(bus_wdata[7:0]);
      end
      // receive queue
      if (wctl && bus_wdata[3]) mrx.delete();
      else begin
        if (bus_rd && bus_addr == 4'd4 && nrx > 0) void'(mrx.pop_front());
        if (rpush) mrx.push_back(rx_data);
      end
      if (setq) m_req = 1;
      else if (wctl && !bus_wdata[10]) m_req = 0;
      if (wctl) begin
        m_txon = bus_wdata[0]; m_rxon = bus_wdata[1];
        m_tien = bus_wdata[9]; m_riien = bus_wdata[11];
      end
      if (bus_wr && bus_addr == 4'd14) m_thr = bus_wdata[15:8];
    end
  endtask

  task automatic cmp_outputs();
    bit ev = m_txon && mtx.size() > 0;
    bit eri = (m_thr != 0 && mrx.size() >= m_thr) || (m_riien && mrx.size() > 0 && m_idle >= 4);
    chk(tx_valid == ev, "R2 tx_valid", tx_valid, ev);
    if (ev) chk(tx_data == mtx[0], "R2 tx_data order", tx_data, mtx[0]);
    chk(rx_ready == (m_rxon && mrx.size() < 128), "R5 rx_ready", rx_ready, m_rxon && mrx.size() < 128);
    chk(tx_irq == (m_tien && m_req), "R8 tx_irq", tx_irq, m_tien && m_req);
    chk(rx_irq == eri, "R10/R11 rx_irq", rx_irq, eri);
  endtask

  task automatic cyc();
    #1;
    chk(bus_rdata == 16'(exp_rdata()), rd_tag(), bus_rdata, exp_rdata());
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_outputs();
  endtask

  task automatic idle_inputs();
    bus_wr = 0; bus_rd = 0; bus_addr = 4'd14; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; char_tick = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    idle_inputs();
  endtask

  task automatic rd(input logic [3:0] a);
    bus_rd = 1; bus_addr = a;
    cyc();
    idle_inputs();
  endtask

  task automatic peek(input logic [3:0] a, input logic [15:0] mask, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk((bus_rdata & mask) == exp, tag, bus_rdata & mask, exp);
  endtask

  task automatic rx_in(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    cyc();
    idle_inputs();
  endtask

  task automatic tick();
    char_tick = 1;
    cyc();
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; tx_ready = 0;
    idle_inputs();
    m_txon = 0; m_rxon = 0; m_tien = 0; m_req = 0; m_riien = 0; m_thr = 0; m_idle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!tx_valid && !rx_ready && !tx_irq && !rx_irq, "R1 outputs after reset",
        {tx_valid, rx_ready, tx_irq, rx_irq}, 0);
    peek(4'd14, 16'hFFFF, 16'h0000, "R1 fills after reset");
    peek(4'd12, 16'hFFFF, 16'h0000, "R1 control after reset");
    cyc();

    // initialisation sequence
    wr(4'd12, 16'h0000);
    wr(4'd12, 16'h000C);
    wr(4'd12, 16'h0803);
    wr(4'd14, 16'h0000);
    wr(4'd14, 16'h1000);

    // R2 transmit order with core stalled then draining
    for (int i = 0; i < 5; i++) wr(4'd4, 16'(8'hA0 + i));
    peek(4'd14, 16'h00FF, 16'h0005, "R4 tx fill low byte");
    chk(tx_data == 8'hA0, "R2 oldest first", tx_data, 8'hA0);
    tx_ready = 1;
    for (int i = 0; i < 3; i++) cyc();
    tx_ready = 0;
    chk(tx_data == 8'hA3, "R2 fifo order after pops", tx_data, 8'hA3);
    tx_ready = 1;
    for (int i = 0; i < 3; i++) cyc();
    tx_ready = 0;

    // R7/R8 data-request flag
    wr(4'd12, 16'h0A03);
    cyc();
    chk(tx_irq == 1, "R8 tx_irq on empty with enable", tx_irq, 1);
    peek(4'd12, 16'h0400, 16'h0400, "R7 request set by hardware");
    wr(4'd4, 16'h0011);
    wr(4'd4, 16'h0022);
    wr(4'd12, 16'h0A03);
    chk(tx_irq == 0, "R7 zero write clears request", tx_irq, 0);
    wr(4'd12, 16'h0E03);
    peek(4'd12, 16'h0400, 16'h0000, "R7 one write does not set request");
    tx_ready = 1;
    for (int i = 0; i < 4; i++) cyc();
    tx_ready = 0;
    chk(tx_irq == 1, "R7 request set again after drain", tx_irq, 1);

    // R3 transmit capacity, R6 flush
    for (int i = 0; i < 130; i++) wr(4'd4, 16'(i));
    peek(4'd14, 16'h00FF, 16'h0080, "R3 tx fill capped at 128");
    wr(4'd12, 16'h0A07);
    peek(4'd14, 16'h00FF, 16'h0000, "R6 tx flush empties");
    peek(4'd12, 16'h000C, 16'h0000, "R6 flush bits read zero");

    // R11 idle interrupt
    rx_in(8'h31); rx_in(8'h32); rx_in(8'h33);
    tick(); tick(); tick();
    chk(rx_irq == 0, "R11 no idle irq after 3 ticks", rx_irq, 0);
    tick();
    chk(rx_irq == 1, "R11 idle irq after 4 ticks", rx_irq, 1);
    rx_in(8'h34);
    chk(rx_irq == 0, "R11 push restarts idle count", rx_irq, 0);

    // R9 reading out, empty read
    bus_addr = 4'd4;
    #1 chk(bus_rdata == 16'h0031, "R9 oldest receive entry", bus_rdata, 16'h0031);
    for (int i = 0; i < 4; i++) rd(4'd4);
    peek(4'd4, 16'hFFFF, 16'h0000, "R9 empty read returns 0");
    rd(4'd4);
    peek(4'd14, 16'hFF00, 16'h0000, "R9 empty read leaves fill");

    // R10 threshold
    for (int i = 0; i < 15; i++) rx_in(8'(8'h40 + i));
    chk(rx_irq == 0, "R10 below threshold", rx_irq, 0);
    rx_in(8'h4F);
    chk(rx_irq == 1, "R10 at threshold", rx_irq, 1);

    // R3 receive capacity
    for (int i = 0; i < 114; i++) rx_in(8'(i));
    peek(4'd14, 16'hFF00, 16'h8000, "R3 rx fill capped at 128");
    chk(rx_ready == 0, "R3 rx_ready low when full", rx_ready, 0);
    wr(4'd12, 16'h0A0B);
    peek(4'd14, 16'hFF00, 16'h0000, "R6 rx flush empties");

    // R5 disabled queues
    wr(4'd12, 16'h0000);
    wr(4'd4, 16'h0055);
    peek(4'd14, 16'h00FF, 16'h0000, "R5 write dropped when tx off");
    chk(!tx_valid && !rx_ready, "R5 handshakes idle when off", {tx_valid, rx_ready}, 0);

    // R12 reserved bits
    wr(4'd12, 16'hFFFF);
    peek(4'd12, 16'hF1FC, 16'h0000, "R12 reserved bits read zero");
    for (int i = 0; i < 3; i++) cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule